// File: doc/BRIEF.md
# Serial Test Pattern Generator

This block produces a repeating serial bit stream, one bit per clock, for driving a serializer or a behavioural line model when AC-coupled differential links are being exercised. A 3-bit code selects one of eight fixed patterns. Some patterns are raw words that are balanced or deliberately unbalanced. One is a long run of ones followed by a long run of zeros. The rest are streams of 10-bit line symbols, already encoded, that either alternate running disparity or hold it at one value. Together the set stresses DC wander on a coupling capacitor and stresses clock recovery through varied transition density.

A strobe marks the first bit of every repeat of the pattern. The select input is sampled only at a repeat boundary, so a stream never contains a fragment of a pattern. An optional squelch holds the output at the idle level for the whole first repeat after reset. Both line legs therefore start from the same level before real data arrives. Deasserting the enable pauses the stream at its current position.

Top module: `serial_pattern_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bit_out` is 0 (the idle level) and `frame_start` is 0.
- R2: With `run` high, one bit is emitted per clock, most significant bit first as written below. `frame_start` is 1 exactly on the first bit of each repeat of the pattern and 0 on every other bit.
- R3: Codes 0, 1 and 2 repeat the 12-bit words 010101001001, 101010101010 and 100000001010 respectively. Code 2 is the unbalanced word, with 3 ones in 12 bits.
- R4: Code 3 repeats an 11-bit period of five ones followed by six zeros: 11111000000.
- R5: Codes 4 and 7 repeat 20-bit periods made of two symbols of opposite disparity. Code 4 is 0011111010 then 1100000101, the comma pair. Code 7 is 1100110110 then 0011000110.
- R6: Codes 5 and 6 repeat the single 10-bit symbols 0111100100 and 1010101010 respectively.
- R7: A change of `pat_sel` in the middle of a repeat has no effect until that repeat has completed. The new pattern starts, with a strobe, at the next boundary.
- R8: While `run` is low, the outputs at the following edge are `bit_out`=0 and `frame_start`=0, and the position is held. When `run` returns high, the stream resumes with the next bit that had not yet been emitted.
- R9: When `squelch_en` is high, every bit of the first repeat after reset is emitted as 0, and the strobe still marks that repeat's first bit. Later repeats carry the pattern unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one unit interval per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Advance the stream when high; pause when low |
| squelch_en | input | 1 | Hold the output idle for the first repeat after reset |
| pat_sel | input | 3 | Pattern code, 0 to 7 |
| bit_out | output | 1 | Serial data bit, registered |
| frame_start | output | 1 | High on the first bit of each repeat, registered |

## Verification
Each of the eight codes is run for two full repeats. This separates the three equal-length 12-bit words from each other and exposes a wrong period length: the 11-, 10- and 20-bit periods misplace the second strobe if the wrap point is wrong. A select change at bit 3 of a repeat distinguishes boundary-only switching from immediate switching. A three-cycle pause in the middle of the run pattern shows whether the position is held, advanced or reset. The squelch run uses the dense 101010 word, so any bit that leaks from the squelched first repeat shows up at once, and the following repeat confirms the squelch releases exactly at the boundary.

// File: rtl/stp_pkg.sv
package stp_pkg;
   localparam int PAT_W = 20;
   localparam int LEN_W = 5;

   typedef enum logic [2:0] {
      PAT_ALT12  = 3'd0,
      PAT_CLK12  = 3'd1,
      PAT_UNBAL  = 3'd2,
      PAT_RUN11  = 3'd3,
      PAT_COMMA  = 3'd4,
      PAT_LOWF   = 3'd5,
      PAT_HIDENS = 3'd6,
      PAT_LOWTR  = 3'd7
   } pat_e;

   typedef struct packed {
      logic [PAT_W-1:0] bits;   // left-aligned, first bit in MSB
      logic [LEN_W-1:0] len;
   } pat_t;

   function automatic pat_t pat_lookup(pat_e code);
      pat_t p;
      case (code)
         PAT_ALT12:  begin p.bits = {12'b010101001001, 8'b0};  p.len = LEN_W'(12); end
         PAT_CLK12:  begin p.bits = {12'b101010101010, 8'b0};  p.len = LEN_W'(12); end
         PAT_UNBAL:  begin p.bits = {12'b100000001010, 8'b0};  p.len = LEN_W'(12); end
         PAT_RUN11:  begin p.bits = {11'b11111000000, 9'b0};   p.len = LEN_W'(11); end
         PAT_COMMA:  begin p.bits = {10'b0011111010, 10'b1100000101}; p.len = LEN_W'(20); end
         PAT_LOWF:   begin p.bits = {10'b0111100100, 10'b0};   p.len = LEN_W'(10); end
         PAT_HIDENS: begin p.bits = {10'b1010101010, 10'b0};   p.len = LEN_W'(10); end
         default:    begin p.bits = {10'b1100110110, 10'b0011000110}; p.len = LEN_W'(20); end
      endcase
      return p;
   endfunction
endpackage

// File: rtl/stp_pattern_rom.sv
module stp_pattern_rom #(
   parameter int SEL_W = 3
) (
   input  logic [SEL_W-1:0] code,
   output stp_pkg::pat_t    pat
);
   if (SEL_W < 3) begin : g_bad_sel
      $error("stp_pattern_rom: SEL_W must be at least 3");
   end

   logic [2:0] code3;

   if (SEL_W == 3) begin : g_direct
      assign code3 = code;
   end else begin : g_fold
      // wider selects fold onto the eight defined codes
      assign code3 = code[2:0];
   end

   always_comb pat = stp_pkg::pat_lookup(stp_pkg::pat_e'(code3));
endmodule

// File: rtl/stp_sequencer.sv
module stp_sequencer #(
   parameter int SEL_W = 3,
   parameter int POS_W = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       run,
   input  logic [SEL_W-1:0]           sel_in,
   input  logic [stp_pkg::LEN_W-1:0]  len,
   output logic [SEL_W-1:0]           eff_code,
   output logic [POS_W-1:0]           pos,
   output logic                       start,
   output logic                       last
);
   logic [SEL_W-1:0] code_q;
   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] len_m1;

   assign len_m1   = POS_W'(len - stp_pkg::LEN_W'(1));
   assign eff_code = (pos_q == '0) ? sel_in : code_q;
   assign pos      = pos_q;
   assign start    = run && (pos_q == '0);
   assign last     = pos_q == len_m1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q  <= '0;
         code_q <= '0;
      end else if (run) begin
         code_q <= eff_code;
         pos_q  <= last ? '0 : pos_q + POS_W'(1);
      end
   end

   AST_WRAP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      run && last |=> pos_q == '0);                                // R2
   AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q != '0 |-> pos_q <= len_m1);                            // R2
   AST_SEL_HELD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
      run && pos_q != '0 |=> $stable(code_q));                     // R7
   AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(pos_q) && $stable(code_q));                 // R8
endmodule

// File: rtl/stp_out_stage.sv
module stp_out_stage #(
   parameter bit IDLE_BIT = 1'b0,
   parameter bit SQUELCH  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic squelch_en,
   input  logic start,
   input  logic last,
   input  logic raw_bit,
   output logic bit_out,
   output logic frame_start
);
   logic squelched;
   logic bit_q;
   logic fs_q;

   if (SQUELCH) begin : g_squelch
      logic first_q;
      always_ff @(posedge clk) begin
         if (!rst_n)          first_q <= 1'b1;
         else if (run && last) first_q <= 1'b0;
      end
      assign squelched = first_q && squelch_en;

      AST_SQUELCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         first_q && squelch_en |=> bit_q == IDLE_BIT);             // R9
      AST_SQUELCH_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
         !first_q |=> !first_q);                                   // R9
   end else begin : g_plain
      logic unused_ok;
      assign unused_ok = squelch_en ^ last;
      assign squelched = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_q <= IDLE_BIT;
         fs_q  <= 1'b0;
      end else begin
         bit_q <= (run && !squelched) ? raw_bit : IDLE_BIT;
         fs_q  <= start;
      end
   end

   assign bit_out     = bit_q;
   assign frame_start = fs_q;

   AST_PAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> bit_q == IDLE_BIT && !fs_q);                        // R8
   AST_STROBE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      fs_q |-> $past(run));                                        // R2
endmodule

// File: rtl/serial_pattern_gen.sv
module serial_pattern_gen #(
   parameter int SEL_W    = 3,
   parameter int MAX_LEN  = 20,
   parameter bit IDLE_BIT = 1'b0,
   parameter bit SQUELCH  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             squelch_en,
   input  logic [SEL_W-1:0] pat_sel,
   output logic             bit_out,
   output logic             frame_start
);
   localparam int POS_W = $clog2(MAX_LEN);

   if (MAX_LEN < stp_pkg::PAT_W) begin : g_bad_len
      $error("serial_pattern_gen: MAX_LEN below longest pattern period");
   end

   logic [SEL_W-1:0]  eff_code;
   logic [POS_W-1:0]  pos;
   logic              start;
   logic              last;
   logic              raw_bit;
   stp_pkg::pat_t     pat;

   stp_pattern_rom #(.SEL_W(SEL_W)) u_rom (
      .code (eff_code),
      .pat  (pat)
   );

   stp_sequencer #(.SEL_W(SEL_W), .POS_W(POS_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .sel_in   (pat_sel),
      .len      (pat.len),
      .eff_code (eff_code),
      .pos      (pos),
      .start    (start),
      .last     (last)
   );

   assign raw_bit = pat.bits[POS_W'(stp_pkg::PAT_W - 1) - pos];

   stp_out_stage #(.IDLE_BIT(IDLE_BIT), .SQUELCH(SQUELCH)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .squelch_en  (squelch_en),
      .start       (start),
      .last        (last),
      .raw_bit     (raw_bit),
      .bit_out     (bit_out),
      .frame_start (frame_start)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> !frame_start && bit_out == IDLE_BIT);             // R1
endmodule

// File: tb/serial_pattern_gen_test.sv
module serial_pattern_gen_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic       squelch_en = 1'b0;
   logic [2:0] pat_sel = 3'd0;
   logic       bit_out;
   logic       frame_start;

   int n_checks = 0;
   int n_fails  = 0;

   always #4 clk = ~clk;   // 125 MHz

   serial_pattern_gen uut (
      .clk(clk), .rst_n(rst_n), .run(run), .squelch_en(squelch_en),
      .pat_sel(pat_sel), .bit_out(bit_out), .frame_start(frame_start)
   );

   function automatic string pat_str(int c);
      case (c)
         0: return "010101001001";
         1: return "101010101010";
         2: return "100000001010";
         3: return "11111000000";
         4: return "00111110101100000101";
         5: return "0111100100";
         6: return "1010101010";
         default: return "11001101100011000110";
      endcase
   endfunction

   function automatic string req_of(int c);
      if (c <= 2) return "R3";
      if (c == 3) return "R4";
      if (c == 4 || c == 7) return "R5";
      return "R6";
   endfunction

   task automatic chk(string req, string what, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   // expects to be called at a negedge; samples one emitted bit per negedge
   task automatic expect_bit(string req, string s, int k, bit squelched);
      logic e;
      @(negedge clk);
      e = squelched ? 1'b0 : (s[k] == "1");
      chk(req, $sformatf("bit %0d of %s", k, s), bit_out, e);
      chk("R2", $sformatf("strobe at bit %0d", k), frame_start, k == 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; run = 1'b0; squelch_en = 1'b0; pat_sel = 3'd0;
      repeat (3) @(negedge clk);
      chk("R1", "bit_out in reset", bit_out, 1'b0);
      chk("R1", "frame_start in reset", frame_start, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "bit_out after reset", bit_out, 1'b0);
      chk("R1", "frame_start after reset", frame_start, 1'b0);
   endtask

   task automatic t_pattern(int code);
      string s = pat_str(code);
      do_reset();
      pat_sel = 3'(code);
      run = 1'b1;
      for (int f = 0; f < 2; f++)
         for (int k = 0; k < s.len(); k++) expect_bit(req_of(code), s, k, 1'b0);
      run = 1'b0;
   endtask

   task automatic t_select_change();
      string a = pat_str(0);
      string b = pat_str(6);
      do_reset();
      pat_sel = 3'd0;
      run = 1'b1;
      for (int k = 0; k < 3; k++) expect_bit("R7", a, k, 1'b0);
      pat_sel = 3'd6;   // mid-repeat change
      for (int k = 3; k < a.len(); k++) expect_bit("R7", a, k, 1'b0);
      for (int k = 0; k < b.len(); k++) expect_bit("R7", b, k, 1'b0);
      run = 1'b0;
   endtask

   task automatic t_pause();
      string s = pat_str(3);
      do_reset();
      pat_sel = 3'd3;
      run = 1'b1;
      for (int k = 0; k < 4; k++) expect_bit("R8", s, k, 1'b0);
      run = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R8", "bit_out while paused", bit_out, 1'b0);
         chk("R8", "frame_start while paused", frame_start, 1'b0);
      end
      run = 1'b1;
      for (int k = 4; k < s.len(); k++) expect_bit("R8", s, k, 1'b0);
      expect_bit("R8", s, 0, 1'b0);
      run = 1'b0;
   endtask

   task automatic t_squelch();
      string s = pat_str(1);
      do_reset();
      squelch_en = 1'b1;
      pat_sel = 3'd1;
      run = 1'b1;
      for (int k = 0; k < s.len(); k++) expect_bit("R9", s, k, 1'b1);
      for (int k = 0; k < s.len(); k++) expect_bit("R9", s, k, 1'b0);
      run = 1'b0;
      squelch_en = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   endtask

   initial begin
      for (int c = 0; c < 8; c++) t_pattern(c);
      t_select_change();
      t_pause();
      t_squelch();
      finish_run();
   end

   initial begin
      #(8 * 200000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule